// File: doc/BRIEF.md
# Endian-Selectable Memory Lane Aligner

This block sits between a 64-bit register datapath and a byte-addressed memory port. For each access it receives an address, a size code (byte, halfword, word or doubleword), a direction flag, a sign flag and a byte-order select. For a store it produces the byte-lane write strobes and a write word that carries the narrow data in every lane group it could occupy. For a load it picks the addressed bytes out of the 64-bit word read from memory and returns them right-justified, zero- or sign-extended.

Byte order can be switched on every access. In little-endian order the byte at the lowest address sits in the least significant lane of the memory word. In big-endian order it sits in the most significant lane. The select changes both the strobes and the load extraction. An access whose address is not a multiple of its size is flagged and produces no strobes and no data. It is never split into several bus cycles. All logic is combinational. A generate option adds one output register stage with a valid bit.

Top module: `mem_lane_aligner`

## Requirements
- R1: `misaligned` is 1 exactly when `req_valid` is 1 and `req_addr` modulo the access size in bytes is not 0. The size codes are 0 = byte (1), 1 = halfword (2), 2 = word (4) and 3 = doubleword (8). When it is 1, `byte_en`, `wr_word` and `rd_data` are all zero.
- R2: Byte lane k means bits 8k+7..8k of the memory word. With `big_endian` = 0, the byte at address offset k (`req_addr[2:0]`) lives in lane k. An aligned store of N bytes at offset o sets `byte_en` bits o to o+N-1 and no others.
- R3: With `big_endian` = 1, the byte at address offset k lives in lane 7-k. An aligned store of N bytes at offset o sets `byte_en` bits 7-o-N+1 to 7-o and no others.
- R4: For an aligned store of N bytes, every lane l of `wr_word` holds byte (l mod N) of `wr_data`. As a result, each enabled lane carries the value byte that belongs at its address: value byte i goes to address o+i when little-endian and to address o+N-1-i when big-endian.
- R5: For an aligned load of N bytes, byte i of `rd_data` is the byte of `rd_word` at address o+i when little-endian, or at address o+N-1-i when big-endian. The address is mapped to a lane as in R2 or R3. A doubleword load returns the whole reordered word.
- R6: A load narrower than 64 bits with `req_signed` = 0 fills `rd_data` above bit 8N-1 with zeros.
- R7: A load narrower than 64 bits with `req_signed` = 1 fills `rd_data` above bit 8N-1 with copies of bit 8N-1 of the extracted value.
- R8: A load (`req_store` = 0) gives `byte_en` = 0 and `wr_word` = 0. A store gives `rd_data` = 0.
- R9: While `req_valid` = 0, `out_valid`, `misaligned`, `byte_en`, `wr_word` and `rd_data` are all zero, whatever the other inputs are.
- R10: With `OUT_REG` = 1, every output shows the result of the request sampled at the previous rising clock edge. While `rst_n` is low they are all zero. With `OUT_REG` = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | 1 = sign-extend a narrow load |
| big_endian | input | 1 | 1 = lowest address in the most significant lane |
| wr_data | input | 64 | Store value, right-justified |
| rd_word | input | 64 | Word read from memory |
| out_valid | output | 1 | Result valid |
| byte_en | output | 8 | Store byte-lane strobes |
| wr_word | output | 64 | Lane-replicated store word |
| rd_data | output | 64 | Extracted and extended load value |
| misaligned | output | 1 | Access not aligned to its size |

## Verification
The registered instance gives every result exactly one rising edge after its request. The bench therefore drives each request on a falling edge and samples that instance one time unit after the next rising edge. A second instance, built without the stage, must show the same results in the cycle of the request. The bench samples it one time unit after driving, before any clock edge. The sweep covers both byte orders, both directions, both sign settings, all four sizes and all eight offsets. Idle cycles are placed in between to confirm that the outputs drop to zero on the next edge.

// File: rtl/lane_pkg.sv
package lane_pkg;
   localparam int unsigned DATA_W = 64;
   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned OFF_W  = $clog2(LANES);

   typedef enum logic [1:0] {
      ACC_BYTE   = 2'd0,
      ACC_HALF   = 2'd1,
      ACC_WORD   = 2'd2,
      ACC_DOUBLE = 2'd3
   } acc_size_e;
endpackage

// File: rtl/lane_locator.sv
module lane_locator
   import lane_pkg::*;
#(
   parameter int unsigned NLANES = lane_pkg::LANES,
   localparam int unsigned OW    = $clog2(NLANES)
) (
   input  logic [OW-1:0] off,
   input  acc_size_e     size,
   input  logic          big,
   output logic [OW:0]   nbytes,
   output logic [OW-1:0] shift,
   output logic [NLANES-1:0] mask,
   output logic          misal
);
   if (NLANES < 8 || (NLANES & (NLANES - 1)) != 0) begin : g_bad_lanes
      $error("lane_locator: NLANES must be a power of two of at least 8");
   end

   logic [OW-1:0] low_bits;

   always_comb begin
      nbytes   = (OW+1)'(1) << size;
      low_bits = OW'(nbytes - 1'b1);
      misal    = (off & low_bits) != '0;
      if (big)
         shift = OW'(int'(NLANES) - int'(off) - int'(nbytes));
      else
         shift = off;
      for (int l = 0; l < int'(NLANES); l++)
         mask[l] = (l >= int'(shift)) && (l < int'(shift) + int'(nbytes));
   end
endmodule

// File: rtl/store_replicate.sv
module store_replicate #(
   parameter int unsigned NLANES = lane_pkg::LANES,
   localparam int unsigned OW    = $clog2(NLANES),
   localparam int unsigned DW    = NLANES * 8
) (
   input  logic [DW-1:0] data,
   input  logic [OW:0]   nbytes,
   output logic [DW-1:0] word
);
   for (genvar l = 0; l < int'(NLANES); l++) begin : g_lane
      logic [OW-1:0] src;
      always_comb begin
         src = OW'(l) & OW'(nbytes - 1'b1);
         word[8*l +: 8] = data[{src, 3'b000} +: 8];
      end
   end
endmodule

// File: rtl/load_extract.sv
module load_extract #(
   parameter int unsigned NLANES = lane_pkg::LANES,
   localparam int unsigned OW    = $clog2(NLANES),
   localparam int unsigned DW    = NLANES * 8,
   localparam int unsigned IW    = $clog2(DW)
) (
   input  logic [DW-1:0] word,
   input  logic [OW-1:0] shift,
   input  logic [OW:0]   nbytes,
   input  logic          sgn,
   output logic [DW-1:0] value
);
   logic [DW-1:0] shifted;
   logic [IW-1:0] top_bit;
   logic          fill;

   always_comb begin
      shifted = word >> {shift, 3'b000};
      top_bit = IW'(int'(nbytes) * 8 - 1);
      fill    = sgn & shifted[top_bit];
      for (int i = 0; i < int'(NLANES); i++)
         value[8*i +: 8] = (i < int'(nbytes)) ? shifted[8*i +: 8] : {8{fill}};
   end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
   import lane_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_store,
   input  logic              req_signed,
   input  logic              big_endian,
   input  logic [63:0]       wr_data,
   input  logic [63:0]       rd_word,
   output logic              out_valid,
   output logic [7:0]        byte_en,
   output logic [63:0]       wr_word,
   output logic [63:0]       rd_data,
   output logic              misaligned
);
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("mem_lane_aligner: ADDR_W must exceed the lane offset width");
   end
   if (OUT_REG > 1) begin : g_bad_reg
      $error("mem_lane_aligner: OUT_REG must be 0 or 1");
   end

   acc_size_e        sz;
   logic [OFF_W:0]   nb;
   logic [OFF_W-1:0] sh;
   logic [LANES-1:0] lane_mask;
   logic             mis_raw;
   logic [DATA_W-1:0] rep_word, ext_word;
   logic             unused_hi;

   assign sz        = acc_size_e'(req_size);
   assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];

   lane_locator #(.NLANES(LANES)) u_loc (
      .off(req_addr[OFF_W-1:0]), .size(sz), .big(big_endian),
      .nbytes(nb), .shift(sh), .mask(lane_mask), .misal(mis_raw)
   );

   store_replicate #(.NLANES(LANES)) u_rep (
      .data(wr_data), .nbytes(nb), .word(rep_word)
   );

   load_extract #(.NLANES(LANES)) u_ext (
      .word(rd_word), .shift(sh), .nbytes(nb), .sgn(req_signed), .value(ext_word)
   );

   logic              c_mis, c_st_ok, c_ld_ok;
   logic [LANES-1:0]  c_be;
   logic [DATA_W-1:0] c_wr, c_rd;

   always_comb begin
      c_mis   = req_valid & mis_raw;
      c_st_ok = req_valid & ~mis_raw & req_store;
      c_ld_ok = req_valid & ~mis_raw & ~req_store;
      c_be    = c_st_ok ? lane_mask : '0;
      c_wr    = c_st_ok ? rep_word  : '0;
      c_rd    = c_ld_ok ? ext_word  : '0;
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            misaligned <= 1'b0;
            byte_en    <= '0;
            wr_word    <= '0;
            rd_data    <= '0;
         end else begin
            out_valid  <= req_valid;
            misaligned <= c_mis;
            byte_en    <= c_be;
            wr_word    <= c_wr;
            rd_data    <= c_rd;
         end
      end

      // R10
      stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> out_valid);
      // R10
      stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !out_valid);
   end else begin : g_comb
      always_comb begin
         out_valid  = req_valid;
         misaligned = c_mis;
         byte_en    = c_be;
         wr_word    = c_wr;
         rd_data    = c_rd;
      end
   end

   // R1
   misal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (byte_en == '0 && wr_word == '0 && rd_data == '0));
   // R2
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && !c_mis) |-> ($countones(c_be) == (1 << req_size)));
   // R6
   zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !req_signed && !c_mis && req_size != 2'd3)
         |-> ((c_rd >> (8 << req_size)) == '0));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!misaligned && byte_en == '0 && wr_word == '0 && rd_data == '0));
endmodule

// File: tb/mem_lane_aligner_test.sv
module mem_lane_aligner_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_store = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
   logic [63:0] wr_data = '0, rd_word = '0;

   logic        r_valid, r_mis, c_valid, c_mis;
   logic [7:0]  r_be, c_be;
   logic [63:0] r_wr, r_rd, c_wr, c_rd;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   mem_lane_aligner #(.ADDR_W(16), .OUT_REG(1)) uut (
      .clk, .rst_n, .req_valid, .req_addr, .req_size, .req_store, .req_signed,
      .big_endian, .wr_data, .rd_word, .out_valid(r_valid), .byte_en(r_be),
      .wr_word(r_wr), .rd_data(r_rd), .misaligned(r_mis)
   );

   mem_lane_aligner #(.ADDR_W(16), .OUT_REG(0)) uut_comb (
      .clk, .rst_n, .req_valid, .req_addr, .req_size, .req_store, .req_signed,
      .big_endian, .wr_data, .rd_word, .out_valid(c_valid), .byte_en(c_be),
      .wr_word(c_wr), .rd_data(c_rd), .misaligned(c_mis)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int lane_of(input logic big, input int a);
      return big ? 7 - a : a;
   endfunction

   initial begin
      #1_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int idx = 0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk("R10", "reset valid", 64'(r_valid), 64'd0);
      chk("R10", "reset be", 64'(r_be), 64'd0);
      chk("R10", "reset rd", r_rd, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int e = 0; e < 2; e++)
       for (int st = 0; st < 2; st++)
        for (int sg = 0; sg < 2; sg++)
         for (int sz = 0; sz < 4; sz++)
          for (int o = 0; o < 8; o++) begin
             int n;
             logic mis;
             logic [7:0]  ebe;
             logic [63:0] ewr, erd, base;
             string tbe, trd;
             n    = 1 << sz;
             mis  = (o % n) != 0;
             base = 64'hF18C_3A75_9E02_B6D4;
             @(negedge clk);
             req_valid  = 1'b1;
             req_addr   = 16'((idx * 8 * 37) & 16'hFFF8) | 16'(o);
             req_size   = 2'(sz);
             req_store  = st[0];
             req_signed = sg[0];
             big_endian = e[0];
             wr_data    = 64'h0123_4567_89AB_CDEF ^ (64'(idx) * 64'h0101_0101_0101_0101);
             rd_word    = (base << (8 * (idx % 8))) | (base >> (64 - 8 * (idx % 8)));
             if (idx % 8 == 0) rd_word = base;
             ebe = '0; ewr = '0; erd = '0;
             if (!mis && st == 1) begin
                for (int j = 0; j < n; j++) ebe[lane_of(e[0], o + j)] = 1'b1;
                for (int l = 0; l < 8; l++) ewr[8*l +: 8] = wr_data[8*(l % n) +: 8];
             end
             if (!mis && st == 0) begin
                for (int i = 0; i < n; i++) begin
                   int a;
                   a = (e == 1) ? o + n - 1 - i : o + i;
                   erd[8*i +: 8] = rd_word[8*lane_of(e[0], a) +: 8];
                end
                if (sg == 1 && n < 8 && erd[8*n-1])
                   for (int i = n; i < 8; i++) erd[8*i +: 8] = 8'hFF;
             end
             tbe = mis ? "R1" : (st == 0 ? "R8" : (e == 1 ? "R3" : "R2"));
             trd = mis ? "R1" : (st == 1 ? "R8" : (n == 8 ? "R5" : (sg == 1 ? "R7" : "R6")));
             #1;
             // R10: variant without output stage, same cycle
             chk("R10", "comb mis", 64'(c_mis), 64'(mis));
             chk("R10", "comb be", 64'(c_be), 64'(ebe));
             chk("R10", "comb rd", c_rd, erd);
             @(posedge clk);
             #1;
             chk("R1", "misaligned", 64'(r_mis), 64'(mis));
             chk(tbe, "byte_en", 64'(r_be), 64'(ebe));
             chk(mis ? "R1" : (st == 1 ? "R4" : "R8"), "wr_word", r_wr, ewr);
             chk(trd, "rd_data", r_rd, erd);
             chk("R10", "valid", 64'(r_valid), 64'd1);
             if (idx % 16 == 15) begin
                @(negedge clk);
                req_valid = 1'b0;
                req_addr  = 16'h0003;
                #1;
                chk("R9", "comb idle be", 64'(c_be), 64'd0);
                @(posedge clk);
                #1;
                // R9: idle request gives quiet outputs
                chk("R9", "idle valid", 64'(r_valid), 64'd0);
                chk("R9", "idle mis", 64'(r_mis), 64'd0);
                chk("R9", "idle be", 64'(r_be), 64'd0);
                chk("R9", "idle wr", r_wr, 64'd0);
                chk("R9", "idle rd", r_rd, 64'd0);
             end
             idx++;
          end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule